// File: doc/BRIEF.md
# MSI Ring-Buffer Logger

This block turns inbound message-signalled interrupt writes into records in a circular log that lives in system memory. Each accepted interrupt word becomes one 16-byte record. The record is written through a simple valid/ready memory-write request port at the ring base address plus the current write offset. The write offset then steps forward by one record and wraps at the end of the ring. Software drains the log by reading records and moving the read offset forward. One summary interrupt line stays high while unread records remain.

A small indexed register port sets up the block. Through it software sets the enables, the ring size (four power-of-two choices scaled from a parameterised minimum), a 64-bit base address and the read offset, and it can read the hardware-owned write offset. When the ring fills, the block can ignore the condition, hold the interrupt source off, or discard the interrupt and record that an overflow happened.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_valid` is low.
- R2: The register indices are: 0 control, 3 base address bits 63:32, 4 base address bits 31:0, 5 read offset, 6 write offset. The control layout is bit 0 enable, bit 1 full detect, bit 3 interrupt enable, bit 4 stop-when-full, bits 9:8 size code and bit 16 overflow. All other control bits read zero. Index 6 ignores writes, and indices 1, 2 and 7 read zero.
- R3: While enable is clear, `msi_ready` is low. Clearing enable keeps both offsets unchanged.
- R4: Each record request has `mem_addr` = base + write offset (64-bit add) and `mem_data[31:0]` = the captured word, with byte 0 in bits 7:0. Bits 127:32 are zero.
- R5: At most one record is in flight. `mem_valid`, `mem_addr` and `mem_data` hold steady until `mem_ready`, and `msi_ready` is low while `mem_valid` is high.
- R6: The write offset moves only on a memory handshake. It advances by 16 and wraps to zero at the ring size of 2^(MIN_LOG2+k) bytes, where k is control bits 9:8.
- R7: A read-offset write is stored as the written value with bits 3:0 and all bits at or above the ring-size boundary cleared. Offsets read back masked the same way.
- R8: The ring is full when (write offset + 16) masked equals the read offset. With full detect and stop-when-full both set, `msi_ready` is low while the ring is full.
- R9: With full detect set, stop-when-full clear and the ring full, an interrupt word is accepted but produces no record. The write offset does not move, and the overflow bit sets. Writing 1 to control bit 16 clears the overflow bit.
- R10: `irq` is high exactly when enable and interrupt enable are set and the read offset differs from the write offset.
- R11: With full detect clear, a full ring still takes a record, and the write offset advances onto the read offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| msi_valid | input | 1 | Inbound interrupt word present |
| msi_data | input | 32 | Inbound interrupt word |
| msi_ready | output | 1 | Block takes the word this cycle |
| mem_valid | output | 1 | Record write request pending |
| mem_addr | output | 64 | Record byte address |
| mem_data | output | 128 | Record contents |
| mem_ready | input | 1 | Memory accepts the record |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions assume that software changes the size code only while no record is in flight. They also assume that offsets are realigned after a size change, so the masked compare stays meaningful. The stimulus rewrites the read offset to the expected write offset after each size change and never touches the size while `mem_valid` is high. `mem_ready` is allowed to drop at any time. The stimulus holds it low across several cycles to exercise the hold-steady rule, and uses base values that carry into the upper 32 address bits.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int IDX_W = 3;
  localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd0;
  localparam logic [IDX_W-1:0] IDX_BASE_HI = 3'd3;
  localparam logic [IDX_W-1:0] IDX_BASE_LO = 3'd4;
  localparam logic [IDX_W-1:0] IDX_RD_OFS  = 3'd5;
  localparam logic [IDX_W-1:0] IDX_WR_OFS  = 3'd6;

  localparam int B_EN    = 0;
  localparam int B_FDET  = 1;
  localparam int B_IEN   = 3;
  localparam int B_STOP  = 4;
  localparam int B_SIZE  = 8;
  localparam int B_OVF   = 16;

  localparam int REC_BYTES = 16;
  localparam int REC_LOG2  = 4;

  typedef struct packed {
    logic       ovf;
    logic [1:0] size;
    logic       stop;
    logic       ien;
    logic       fdet;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int OFS_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             ovf_set,
  input  logic [OFS_W-1:0] mask,
  input  logic [OFS_W-1:0] wofs,
  output ctrl_t            ctrl,
  output logic [63:0]      base,
  output logic [OFS_W-1:0] rofs
);
  ctrl_t            ctrl_q, ctrl_n;
  logic [31:0]      bhi_q, bhi_n, blo_q, blo_n;
  logic [OFS_W-1:0] rofs_q, rofs_n;
  logic             ctrl_wr;

  assign ctrl_wr = cfg_we && (cfg_addr == IDX_CTRL);

  always_comb begin
    ctrl_n = ctrl_q;
    bhi_n  = bhi_q;
    blo_n  = blo_q;
    rofs_n = rofs_q;
    if (cfg_we) begin
      case (cfg_addr)
        IDX_CTRL: begin
          ctrl_n.en   = cfg_wdata[B_EN];
          ctrl_n.fdet = cfg_wdata[B_FDET];
          ctrl_n.ien  = cfg_wdata[B_IEN];
          ctrl_n.stop = cfg_wdata[B_STOP];
          ctrl_n.size = cfg_wdata[B_SIZE +: 2];
          ctrl_n.ovf  = ctrl_q.ovf & ~cfg_wdata[B_OVF];
        end
        IDX_BASE_HI: bhi_n = cfg_wdata;
        IDX_BASE_LO: blo_n = cfg_wdata;
        IDX_RD_OFS:  rofs_n = cfg_wdata[OFS_W-1:0] & mask;
        default: ;
      endcase
    end
    if (ovf_set) ctrl_n.ovf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      bhi_q  <= '0;
      blo_q  <= '0;
      rofs_q <= '0;
    end else begin
      ctrl_q <= ctrl_n;
      bhi_q  <= bhi_n;
      blo_q  <= blo_n;
      rofs_q <= rofs_n;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      IDX_CTRL: begin
        cfg_rdata[B_EN]       = ctrl_q.en;
        cfg_rdata[B_FDET]     = ctrl_q.fdet;
        cfg_rdata[B_IEN]      = ctrl_q.ien;
        cfg_rdata[B_STOP]     = ctrl_q.stop;
        cfg_rdata[B_SIZE +: 2] = ctrl_q.size;
        cfg_rdata[B_OVF]      = ctrl_q.ovf;
      end
      IDX_BASE_HI: cfg_rdata = bhi_q;
      IDX_BASE_LO: cfg_rdata = blo_q;
      IDX_RD_OFS:  cfg_rdata = 32'(rofs_q & mask);
      IDX_WR_OFS:  cfg_rdata = 32'(wofs);
      default:     cfg_rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign base = {bhi_q, blo_q};
  assign rofs = rofs_q;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.ovf && !(ctrl_wr && cfg_wdata[B_OVF])) |=> ctrl_q.ovf); // R9
endmodule

// File: rtl/msi_ring_ofs.sv
module msi_ring_ofs
  import msi_ring_pkg::*;
#(
  parameter int MIN_LOG2 = 15,
  parameter int OFS_W    = MIN_LOG2 + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       size_sel,
  input  logic [OFS_W-1:0] rofs,
  input  logic             advance,
  output logic [OFS_W-1:0] mask,
  output logic [OFS_W-1:0] wofs,
  output logic             empty,
  output logic             full
);
  logic [OFS_W-1:0] wofs_q, wofs_n, nxt, rofs_m;

  always_comb begin
    for (int i = 0; i < OFS_W; i++)
      mask[i] = (i >= REC_LOG2) && (i < MIN_LOG2 + int'(size_sel));
  end

  assign wofs   = wofs_q & mask;
  assign rofs_m = rofs & mask;
  assign nxt    = (wofs + OFS_W'(REC_BYTES)) & mask;
  assign empty  = (wofs == rofs_m);
  assign full   = (nxt == rofs_m);

  always_comb begin
    wofs_n = wofs_q;
    if (advance) wofs_n = nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wofs_q <= '0;
    else        wofs_q <= wofs_n;
  end

  AST_WOFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(wofs_q)); // R6
endmodule

// File: rtl/msi_ring_req.sv
module msi_ring_req
  import msi_ring_pkg::*;
#(
  parameter int OFS_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             full,
  input  logic [63:0]      base,
  input  logic [OFS_W-1:0] wofs,
  input  logic             msi_valid,
  input  logic [31:0]      msi_data,
  output logic             msi_ready,
  output logic             mem_valid,
  output logic [63:0]      mem_addr,
  output logic [127:0]     mem_data,
  input  logic             mem_ready,
  output logic             advance,
  output logic             drop
);
  logic         busy_q, busy_n;
  logic [63:0]  addr_q, addr_n;
  logic [31:0]  word_q, word_n;
  logic         hold, accept, load;

  assign hold      = ctrl.fdet & full;
  assign msi_ready = ctrl.en & ~busy_q & ~(hold & ctrl.stop);
  assign accept    = msi_valid & msi_ready;
  assign drop      = accept & hold;
  assign load      = accept & ~hold;
  assign advance   = busy_q & mem_ready;

  always_comb begin
    busy_n = busy_q;
    addr_n = addr_q;
    word_n = word_q;
    if (advance) busy_n = 1'b0;
    if (load) begin
      busy_n = 1'b1;
      addr_n = base + 64'(wofs);
      word_n = msi_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      word_q <= '0;
    end else begin
      busy_q <= busy_n;
      addr_q <= addr_n;
      word_q <= word_n;
    end
  end

  assign mem_valid = busy_q;
  assign mem_addr  = addr_q;
  assign mem_data  = {96'd0, word_q};

  AST_MEM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !msi_ready); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_data[127:32] == '0)); // R4
  AST_STOP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.fdet && ctrl.stop && full) |-> !msi_ready); // R8
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> !msi_ready); // R3
  AST_DROP_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !mem_valid); // R9
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
#(
  parameter int MIN_LOG2 = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_addr,
  input  logic [31:0]  cfg_wdata,
  output logic [31:0]  cfg_rdata,
  input  logic         msi_valid,
  input  logic [31:0]  msi_data,
  output logic         msi_ready,
  output logic         mem_valid,
  output logic [63:0]  mem_addr,
  output logic [127:0] mem_data,
  input  logic         mem_ready,
  output logic         irq
);
  localparam int OFS_W = MIN_LOG2 + 3;

  ctrl_t            ctrl;
  logic [63:0]      base;
  logic [OFS_W-1:0] rofs, wofs, mask;
  logic             empty, full, advance, drop;

  msi_ring_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ovf_set(drop),
    .mask(mask), .wofs(wofs), .ctrl(ctrl), .base(base), .rofs(rofs)
  );

  msi_ring_ofs #(.MIN_LOG2(MIN_LOG2), .OFS_W(OFS_W)) u_ofs (
    .clk(clk), .rst_n(rst_n), .size_sel(ctrl.size), .rofs(rofs),
    .advance(advance), .mask(mask), .wofs(wofs), .empty(empty), .full(full)
  );

  msi_ring_req #(.OFS_W(OFS_W)) u_req (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .full(full), .base(base),
    .wofs(wofs), .msi_valid(msi_valid), .msi_data(msi_data),
    .msi_ready(msi_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .advance(advance), .drop(drop)
  );

  assign irq = ctrl.en & ctrl.ien & ~empty;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctrl.en && ctrl.ien)); // R10
  AST_DROP_KEEPS_WOFS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !mem_valid) |=> $stable(wofs)); // R9
endmodule

// File: tb/tb_msi_ring_ctrl.sv
module tb_msi_ring_ctrl;
  localparam int MINL = 6;

  logic         clk, rst_n, cfg_we, msi_valid, mem_ready;
  logic [2:0]   cfg_addr;
  logic [31:0]  cfg_wdata, cfg_rdata, msi_data;
  logic         msi_ready, mem_valid, irq;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;

  int nchk = 0, nbad = 0;
  bit finished = 0;
  logic [63:0] base64;
  int exp_wofs, exp_rofs, size_b;

  msi_ring_ctrl #(.MIN_LOG2(MINL)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msi_valid(msi_valid),
    .msi_data(msi_data), .msi_ready(msi_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_we = 0; cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic set_base(input logic [31:0] hi, input logic [31:0] lo);
    cfg_write(3'd3, hi); cfg_write(3'd4, lo); base64 = {hi, lo};
  endtask

  task automatic send_msi(input logic [31:0] d);
    @(negedge clk); msi_valid = 1; msi_data = d; #1;
    for (int n = 0; n < 50 && !msi_ready; n++) begin @(negedge clk); #1; end
    @(negedge clk); msi_valid = 0;
  endtask

  task automatic push_chk(input string req, input logic [31:0] d);
    logic [31:0] r;
    logic [63:0] ea;
    ea = base64 + 64'(exp_wofs);
    send_msi(d); #1;
    chk(req, "mem_valid", 128'(mem_valid), 128'(1));
    chk("R4", "mem_addr", 128'(mem_addr), 128'(ea));
    chk("R4", "mem_data", mem_data, {96'd0, d});
    exp_wofs = (exp_wofs + 16) % size_b;
    cfg_read(3'd6, r);
    chk("R6", "wofs", 128'(r), 128'(exp_wofs));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    msi_valid = 0; msi_data = 0; mem_ready = 1;
    exp_wofs = 0; exp_rofs = 0; base64 = 0; size_b = 1 << MINL;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    foreach (r[i]) ; // no-op to keep r declared
    for (int a = 0; a < 8; a++) begin
      cfg_read(3'(a), r);
      chk("R1", "reg after reset", 128'(r), 128'(0));
    end
    chk("R1", "irq", 128'(irq), 128'(0));
    chk("R1", "mem_valid", 128'(mem_valid), 128'(0));

    // R3: disabled block refuses words
    @(negedge clk); msi_valid = 1; #1;
    chk("R3", "msi_ready disabled", 128'(msi_ready), 128'(0));
    @(negedge clk); msi_valid = 0;

    // R2: register map and control layout
    set_base(32'h1, 32'hFFFF_FFC0);
    cfg_read(3'd3, r); chk("R2", "base hi", 128'(r), 128'(32'h1));
    cfg_read(3'd4, r); chk("R2", "base lo", 128'(r), 128'(32'hFFFF_FFC0));
    cfg_write(3'd0, 32'hFFFF_FFFF);
    cfg_read(3'd0, r); chk("R2", "ctrl layout", 128'(r), 128'(32'h31B));
    cfg_write(3'd1, 32'h5); cfg_write(3'd2, 32'h5); cfg_write(3'd7, 32'h5);
    cfg_read(3'd1, r); chk("R2", "idx1", 128'(r), 128'(0));
    cfg_read(3'd2, r); chk("R2", "idx2", 128'(r), 128'(0));
    cfg_read(3'd7, r); chk("R2", "idx7", 128'(r), 128'(0));

    // R6/R4/R10: sweep every size code, pushing past one wrap
    for (int k = 0; k < 4; k++) begin
      size_b = 1 << (MINL + k);
      exp_wofs = exp_wofs % size_b;
      set_base(32'(k + 1), 32'hFFFF_FF00);
      cfg_write(3'd0, 32'h9 | (k << 8));
      cfg_write(3'd5, 32'(exp_wofs));
      exp_rofs = exp_wofs;
      #1 chk("R10", "irq empty", 128'(irq), 128'(0));
      for (int i = 0; i < size_b / 16 + 2; i++) begin
        push_chk("R6", 32'hA500_0000 | (k << 16) | i);
        if (i == 0) chk("R10", "irq nonempty", 128'(irq), 128'(1));
      end
      cfg_write(3'd0, 32'h1 | (k << 8));
      #1 chk("R10", "irq ien clear", 128'(irq), 128'(0));
      cfg_write(3'd0, 32'h9 | (k << 8));
      cfg_write(3'd5, 32'(exp_wofs));
      exp_rofs = exp_wofs;
      #1 chk("R10", "irq drained", 128'(irq), 128'(0));
    end

    // R5: back-pressure on memory port
    size_b = 1 << MINL;
    exp_wofs = exp_wofs % size_b;
    set_base(32'h0, 32'h1000);
    cfg_write(3'd0, 32'h1);
    mem_ready = 0;
    send_msi(32'h1234_5678); #1;
    chk("R5", "mem_valid held", 128'(mem_valid), 128'(1));
    chk("R5", "addr", 128'(mem_addr), 128'(64'h1000 + 64'(exp_wofs)));
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); #1;
      chk("R5", "still valid", 128'(mem_valid), 128'(1));
      chk("R5", "addr stable", 128'(mem_addr), 128'(64'h1000 + 64'(exp_wofs)));
      chk("R5", "msi_ready low", 128'(msi_ready), 128'(0));
    end
    cfg_read(3'd6, r); chk("R6", "no advance before ready", 128'(r), 128'(exp_wofs));
    mem_ready = 1;
    @(negedge clk); #1;
    chk("R5", "valid drops", 128'(mem_valid), 128'(0));
    exp_wofs = (exp_wofs + 16) % size_b;
    cfg_read(3'd6, r); chk("R6", "advance after ready", 128'(r), 128'(exp_wofs));

    // R7: read offset masking; R2: write offset not writable
    cfg_write(3'd5, 32'hFFFF_FFFF);
    cfg_read(3'd5, r); chk("R7", "rofs mask k0", 128'(r), 128'(32'h30));
    cfg_write(3'd0, 32'h301);
    cfg_write(3'd5, 32'hFFFF_FFFF);
    cfg_read(3'd5, r); chk("R7", "rofs mask k3", 128'(r), 128'(32'h1F0));
    cfg_write(3'd6, 32'h40);
    cfg_read(3'd6, r); chk("R2", "wofs read-only", 128'(r), 128'(exp_wofs));

    // R8: stop-when-full
    cfg_write(3'd0, 32'h13);
    size_b = 1 << MINL;
    cfg_write(3'd5, 32'(exp_wofs));
    exp_rofs = exp_wofs;
    for (int i = 0; i < 3; i++) push_chk("R8", 32'hB000_0000 + i);
    #1 chk("R8", "ready low when full", 128'(msi_ready), 128'(0));
    exp_rofs = (exp_rofs + 16) % size_b;
    cfg_write(3'd5, 32'(exp_rofs));
    #1 chk("R8", "ready after space", 128'(msi_ready), 128'(1));
    push_chk("R8", 32'hB000_0010);
    #1 chk("R8", "full again", 128'(msi_ready), 128'(0));

    // R9: discard on full
    cfg_write(3'd0, 32'h3);
    send_msi(32'hDEAD_BEEF); #1;
    chk("R9", "no record", 128'(mem_valid), 128'(0));
    cfg_read(3'd6, r); chk("R9", "wofs kept", 128'(r), 128'(exp_wofs));
    cfg_read(3'd0, r); chk("R9", "ovf set", 128'(r), 128'(32'h10003));
    cfg_write(3'd0, 32'h10003);
    cfg_read(3'd0, r); chk("R9", "ovf cleared", 128'(r), 128'(32'h3));

    // R11: overwrite with full detect off
    cfg_write(3'd0, 32'h9);
    push_chk("R11", 32'hC0DE_0001);
    chk("R11", "wofs reaches rofs", 128'(exp_wofs), 128'(exp_rofs));
    #1 chk("R10", "irq after overwrite", 128'(irq), 128'(0));

    // R3: disabling keeps offsets
    cfg_write(3'd0, 32'h0);
    cfg_read(3'd6, r); chk("R3", "wofs kept", 128'(r), 128'(exp_wofs));
    cfg_read(3'd5, r); chk("R3", "rofs kept", 128'(r), 128'(exp_rofs));
    #1 chk("R3", "ready low", 128'(msi_ready), 128'(0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule